// File: doc/BRIEF.md
# Smart Card Contact Activation Sequencer

This block steps one smart card contact set through power-up and power-down. A host raises an enable request. The sequencer then switches on the card supply and holds reset, clock and I/O low while the supply ramps. Once a supply-good indication arrives, it waits a fixed settling time and frees reset and I/O. Two reference cycles later it starts passing the free-running reference clock to the card.

Dropping the enable request tears the session down in a fixed order:

1. Reset is pulled low at once.
2. The clock stops two reference cycles later.
3. I/O is clamped low.
4. The supply is switched off last.

If the supply never reports good within a timeout, the block flags a fault and runs the same teardown. The fault also blocks a restart until the enable request is withdrawn. Enable and supply-good are asynchronous inputs and pass through two-flop synchronizers. A two-bit status output tells the host which phase the contact set is in.

Top module: `card_act_seq`

## Requirements
- R1: When the synchronized enable is high in idle with no fault pending, `card_vcc_en` rises and `status` becomes 1 on the third rising reference edge after `en_in` goes high.
- R2: While `status` is 1 (powering), `card_rst` is low, `io_force_low` is high and `card_clk` shows no rising edge.
- R3: `card_vsel` (0 selects the 1.8 V level, 1 selects the 3.0 V level) takes the value of `vsel_in` when activation starts. Later changes of `vsel_in` have no effect until the next activation.
- R4: Exactly `RELEASE_CYC` reference cycles after the synchronized supply-good is first seen, `card_rst` goes high, `io_force_low` goes low and `status` becomes 2.
- R5: The first rising edge of `card_clk` comes on the second rising reference edge after the release of R4. From then on it follows the reference clock each cycle with full-length high and low phases.
- R6: When the synchronized enable is seen low in the powering or active phase, `card_rst` goes low on that same edge and `status` becomes 3.
- R7: The last rising edge of `card_clk` occurs two reference cycles after the edge of R6, and no later edge follows. If the clock was not yet running, it stays low.
- R8: `io_force_low` rises one cycle after the clock stops. On the cycle after that, `card_vcc_en` falls and `status` returns to 0.
- R9: If enable rises again during deactivation, the teardown still completes. A new activation starts on the cycle after idle is reached.
- R10: If supply-good is not seen within `TIMEOUT_CYC` cycles of activation start, `fault` is set and the teardown of R6 to R8 runs. While `fault` is set, the block stays idle even with enable high. Enable seen low in idle clears `fault`.
- R11: Reset leaves `card_vcc_en`, `card_rst`, `card_clk` and `fault` low, `io_force_low` high and `status` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, also the card clock source |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Asynchronous activation request |
| vgood_in | input | 1 | Asynchronous card supply-good indication |
| vsel_in | input | 1 | Supply level select: 0 for 1.8 V, 1 for 3.0 V |
| card_vcc_en | output | 1 | Card supply enable |
| card_vsel | output | 1 | Supply level latched at activation |
| card_rst | output | 1 | Card reset line |
| card_clk | output | 1 | Gated card clock |
| io_force_low | output | 1 | 1 clamps card I/O low, 0 releases it to the data path |
| fault | output | 1 | Supply-good timeout flag |
| status | output | 2 | 0 idle, 1 powering, 2 active, 3 deactivating |

## Verification
A phase register that is wrong shows up on the `status` code within one cycle. It also shows up on the contact lines in the same cycle: for example, reset or I/O freed while still powering. A settling or teardown counter that is off by one moves the release edge or the supply-off edge by a cycle. The bench therefore samples those lines on the exact cycle before and after each expected change. A clock enable that is wrong changes how many `card_clk` rising edges the bench counts. That count is checked one cycle before and one cycle after the first edge and the last edge.

// File: rtl/card_act_seq.sv
module card_act_seq #(
  parameter int RELEASE_CYC = 3200,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  input  logic       vgood_in,
  input  logic       vsel_in,
  output logic       card_vcc_en,
  output logic       card_vsel,
  output logic       card_rst,
  output logic       card_clk,
  output logic       io_force_low,
  output logic       fault,
  output logic [1:0] status
);
  localparam int MAXC = (RELEASE_CYC > TIMEOUT_CYC) ? RELEASE_CYC : TIMEOUT_CYC;
  localparam int CW   = (MAXC < 4) ? 2 : $clog2(MAXC + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_PWR = 2'd1, S_ACT = 2'd2, S_DEA = 2'd3;

  logic [1:0]    en_sy, vg_sy;
  logic          en_s, vg_s;
  logic          ramped, clk_run, gate;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_sy <= '0;
      vg_sy <= '0;
    end else begin
      en_sy <= {en_sy[0], en_in};
      vg_sy <= {vg_sy[0], vgood_in};
    end

  assign en_s = en_sy[1];
  assign vg_s = vg_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status       <= S_IDLE;
      card_vcc_en  <= 1'b0;
      card_vsel    <= 1'b0;
      card_rst     <= 1'b0;
      io_force_low <= 1'b1;
      clk_run      <= 1'b0;
      fault        <= 1'b0;
      ramped       <= 1'b0;
      cnt          <= '0;
    end else begin
      case (status)
        S_IDLE:
          if (!en_s) fault <= 1'b0;
          else if (!fault) begin
            status      <= S_PWR;
            card_vcc_en <= 1'b1;
            card_vsel   <= vsel_in;
            ramped      <= 1'b0;
            cnt         <= '0;
          end
        S_PWR:
          if (!en_s) begin
            status   <= S_DEA;
            card_rst <= 1'b0;
            cnt      <= '0;
          end else if (!ramped) begin
            if (vg_s) begin
              ramped <= 1'b1;
              cnt    <= '0;
            end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
              fault  <= 1'b1;
              status <= S_DEA;
              cnt    <= '0;
            end else cnt <= cnt + 1'b1;
          end else if (cnt == CW'(RELEASE_CYC - 1)) begin
            status       <= S_ACT;
            card_rst     <= 1'b1;
            io_force_low <= 1'b0;
          end else cnt <= cnt + 1'b1;
        S_ACT:
          if (!en_s) begin
            status   <= S_DEA;
            card_rst <= 1'b0;
            cnt      <= '0;
          end else clk_run <= 1'b1;
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) clk_run <= 1'b0;
          if (cnt == CW'(2)) io_force_low <= 1'b1;
          if (cnt == CW'(3)) begin
            card_vcc_en <= 1'b0;
            status      <= S_IDLE;
          end
        end
      endcase
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) gate <= 1'b0;
    else        gate <= clk_run;

  assign card_clk = clk & gate;
endmodule

// File: rtl/card_act_seq_chk.sv
module card_act_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_s,
  input logic       fault,
  input logic [1:0] status,
  input logic       card_vcc_en,
  input logic       card_vsel,
  input logic       card_rst,
  input logic       io_force_low,
  input logic       clk_run
);
  a_r1_supply_on: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && en_s && !fault) |=> (card_vcc_en && status == 2'd1));

  a_r2_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1) |-> (!card_rst && io_force_low && !clk_run));

  a_r3_vsel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0 && $past(status) != 2'd0) |-> $stable(card_vsel));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> (status == 2'd2 && !io_force_low && card_vcc_en));

  a_r6_rst_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 && !en_s) |=> (!card_rst && status == 2'd3));

  a_r8_supply_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_vcc_en) |-> (io_force_low && !clk_run && status == 2'd0));

  a_r10_fault_teardown: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (status == 2'd3 && !card_rst));
endmodule

bind card_act_seq card_act_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .fault(fault), .status(status),
  .card_vcc_en(card_vcc_en), .card_vsel(card_vsel), .card_rst(card_rst),
  .io_force_low(io_force_low), .clk_run(clk_run)
);

// File: tb/tb_card_act_seq.sv
module tb_card_act_seq;
  localparam int REL = 16;
  localparam int TMO = 40;
  // {vsel[8], supply-good delay in cycles [7:1], fault expected [0]}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 7'd0,   1'b0},
    {1'b1, 7'd10,  1'b0},
    {1'b0, 7'd37,  1'b0},
    {1'b1, 7'd5,   1'b0},
    {1'b0, 7'd127, 1'b1},
    {1'b1, 7'd38,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, en_in = 1'b0, vgood_in = 1'b0, vsel_in = 1'b0;
  logic card_vcc_en, card_vsel, card_rst, card_clk, io_force_low, fault;
  logic [1:0] status;
  int nchk = 0, nerr = 0, ccnt = 0;
  bit done = 1'b0;

  card_act_seq #(.RELEASE_CYC(REL), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .vgood_in(vgood_in), .vsel_in(vsel_in),
    .card_vcc_en(card_vcc_en), .card_vsel(card_vsel), .card_rst(card_rst),
    .card_clk(card_clk), .io_force_low(io_force_low), .fault(fault), .status(status));

  always #2 clk = ~clk;
  always @(posedge card_clk) ccnt <= ccnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic teardown_running();
    int ca;
    en_in = 1'b0;
    tick(2);
    chk("R6 rst before sync", card_rst, 1);
    tick(1);
    chk("R6 rst low", card_rst, 0);
    chk("R6 status", status, 3);
    ca = ccnt;
    tick(2);
    chk("R7 last edges", ccnt, ca + 2);
    chk("R8 io before", io_force_low, 0);
    tick(1);
    chk("R8 io clamp", io_force_low, 1);
    chk("R8 supply still on", card_vcc_en, 1);
    tick(1);
    chk("R8 supply off", card_vcc_en, 0);
    chk("R8 idle", status, 0);
    tick(2);
    chk("R7 no edge after", ccnt, ca + 2);
    vgood_in = 1'b0;
    tick(3);
  endtask

  initial begin
    tick(3);
    chk("R11 vcc", card_vcc_en, 0);
    chk("R11 rst", card_rst, 0);
    chk("R11 io", io_force_low, 1);
    chk("R11 status", status, 0);
    chk("R11 fault", fault, 0);
    chk("R11 clk", ccnt, 0);
    rst_n = 1'b1;
    tick(2);

    foreach (VEC[i]) begin
      automatic logic v = VEC[i][8];
      automatic int d = int'(VEC[i][7:1]);
      automatic logic fx = VEC[i][0];
      automatic int c0;
      vsel_in = v;
      en_in = 1'b1;
      tick(2);
      chk("R1 supply early", card_vcc_en, 0);
      tick(1);
      chk("R1 supply on", card_vcc_en, 1);
      chk("R1 status", status, 1);
      vsel_in = ~v;
      chk("R2 rst held", card_rst, 0);
      chk("R2 io held", io_force_low, 1);
      c0 = ccnt;
      if (!fx) begin
        tick(d);
        vgood_in = 1'b1;
        tick(2 + REL);
        chk("R4 not yet", card_rst, 0);
        chk("R2 io still held", io_force_low, 1);
        chk("R2 no clock", ccnt, c0);
        tick(1);
        chk("R4 rst released", card_rst, 1);
        chk("R4 io released", io_force_low, 0);
        chk("R4 status", status, 2);
        chk("R3 vsel latched", card_vsel, v);
        tick(1);
        chk("R5 no edge yet", ccnt, c0);
        tick(1);
        chk("R5 first edge", ccnt, c0 + 1);
        tick(1);
        chk("R5 running", ccnt, c0 + 2);
        teardown_running();
      end else begin
        for (int t = 1; t <= TMO; t++) begin
          tick(1);
          if (t == d) vgood_in = 1'b1;
          if (t == TMO - 1) chk("R10 no fault yet", fault, 0);
        end
        chk("R10 fault set", fault, 1);
        chk("R10 status", status, 3);
        chk("R10 rst low", card_rst, 0);
        tick(4);
        chk("R10 supply off", card_vcc_en, 0);
        chk("R10 io clamped", io_force_low, 1);
        chk("R3 vsel latched", card_vsel, v);
        tick(3);
        chk("R10 no restart", status, 0);
        chk("R10 still off", card_vcc_en, 0);
        chk("R2 no clock", ccnt, c0);
        en_in = 1'b0;
        vgood_in = 1'b0;
        tick(2);
        chk("R10 fault held", fault, 1);
        tick(1);
        chk("R10 fault cleared", fault, 0);
        tick(2);
      end
    end

    // R9: enable returns during teardown
    en_in = 1'b1;
    tick(3);
    vgood_in = 1'b1;
    tick(3 + REL + 3);
    chk("R9 active first", status, 2);
    en_in = 1'b0;
    tick(3);
    chk("R9 deactivating", status, 3);
    en_in = 1'b1;
    tick(4);
    chk("R9 idle reached", status, 0);
    chk("R9 supply off", card_vcc_en, 0);
    tick(1);
    chk("R9 restart", status, 1);
    chk("R9 supply back", card_vcc_en, 1);
    en_in = 1'b0;
    vgood_in = 1'b0;
    tick(10);
    chk("R9 idle after", status, 0);

    // R7: teardown from powering, clock never started
    begin
      automatic int cb = ccnt;
      en_in = 1'b1;
      tick(4);
      en_in = 1'b0;
      tick(3);
      chk("R6 status from powering", status, 3);
      tick(6);
      chk("R7 clock stays low", ccnt, cb);
      chk("R8 idle from powering", status, 0);
      chk("R8 supply off from powering", card_vcc_en, 0);
    end

    summary();
    done = 1'b1;
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule